// File: doc/BRIEF.md
# Waveform Start Trigger Router

This block picks one pin out of a bus of general-purpose trigger inputs and watches it for the edge that starts DAC waveform generation. A select field chooses the pin. A polarity bit chooses whether a rising or a falling transition counts. Every pin passes through its own two-flop synchronizer. Edges are found per pin before the select mux, so changing the select or the polarity never creates a transition that did not happen on a pin.

Software arms the block with a one-cycle `arm` pulse. The first qualifying edge after arming produces a single-cycle `start_strobe` to the waveform engine and disarms the block. Later edges do nothing until the block is armed again.

The same event drives a dedicated trigger output. This output is an active-high pulse of fixed length, and it mirrors whichever pin actually started generation. The length is computed from the clock frequency and a target width, which gives two cycles (50 ns) at 40 MHz. The output pad enable is low from reset, so the pin stays high-impedance until `out_en` is set.

Top module: `wave_start_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `start_strobe`, `trig_out` and `trig_out_en` are all 0.
- R2: With `fall_edge`=0, a 0-to-1 change on the selected pin while armed makes `start_strobe` high for exactly one cycle. That cycle is the third rising clock edge after the pin change: two synchronizer stages plus one output register.
- R3: With `fall_edge`=1, a 0-to-1 change on the selected pin does not fire. The following 1-to-0 change fires, with the same latency as R2.
- R4: Transitions on pins other than the one `src_sel` names never produce a strobe.
- R5: After a strobe the block is disarmed. Further qualifying edges produce no strobe until another `arm` pulse.
- R6: After reset and before the first `arm` pulse, qualifying edges produce no strobe.
- R7: `trig_out` goes high in the same cycle as `start_strobe` and stays high for exactly PULSE_CYCLES = ceil(PULSE_NS × CLK_HZ / 1e9) cycles. That is 2 cycles for the defaults of 50 ns at 40 MHz.
- R8: `trig_out_en` equals the value `out_en` had one clock earlier.
- R9: `src_sel` values 0 to NUM_PINS-1 select that pin, including the highest index. Values of NUM_PINS and above select no pin, and nothing fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous trigger input pins |
| src_sel | input | SEL_W | Index of the trigger source pin |
| fall_edge | input | 1 | 0 = rising edge qualifies, 1 = falling edge qualifies |
| out_en | input | 1 | Request to drive the trigger output pad |
| arm | input | 1 | One-cycle pulse that arms the block for one start |
| start_strobe | output | 1 | One-cycle start pulse to the waveform engine |
| trig_out | output | 1 | Active-high mirrored trigger pulse |
| trig_out_en | output | 1 | Pad drive enable; 0 means high-impedance |

## Verification
The bench aims at the edges that must be ignored. These are edges before the first arm, a second edge after a start, the wrong polarity, a pin that is not selected, and a select value past the last pin. A design that got any of these wrong would emit an extra start strobe, and the scoreboard flags that strobe as unexpected. Strobe latency is compared to the exact cycle. A synchronizer with a missing or extra stage therefore shows up as a strobe one cycle early or late. The output pulse is compared every cycle, so a pulse one cycle short or long, or one that starts apart from the strobe, is caught. The highest valid pin index is exercised as well, which catches an off-by-one in the select decode.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  // Clock cycles needed to cover a pulse of width_ns at clk_hz, rounded up.
  function automatic int pulse_cycles(input longint clk_hz, input longint width_ns);
    longint num;
    num = width_ns * clk_hz;
    return int'((num + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  // Edge qualification for one pin: current and previous synchronized level.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic falling);
    return falling ? (prev & ~cur) : (cur & ~prev);
  endfunction

  // Width of a down-counter that must hold the value n.
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/wsr_pin_sync.sv
module wsr_pin_sync #(
  parameter int NUM_PINS = 10,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_async,
  output logic [NUM_PINS-1:0] pin_sync
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else if (STAGES == 1) chain <= pin_async[p];
      else chain <= {chain[STAGES-2:0], pin_async[p]};
    end
    assign pin_sync[p] = chain[STAGES-1];
  end

endmodule

// File: rtl/wsr_edge_pick.sv
module wsr_edge_pick
  import wsr_pkg::*;
#(
  parameter int NUM_PINS = 10,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [SEL_W-1:0]    src_sel,
  input  logic                fall_edge,
  output logic                edge_sel
);

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= pin_sync;
  end

  // Edge found on every pin before the mux, so select changes never invent one.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_hit
    assign hit[p] = edge_hit(pin_sync[p], prev_q[p], fall_edge);
  end

  always_comb begin
    edge_sel = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (int'(src_sel) == i) edge_sel = hit[i];
    end
  end

endmodule

// File: rtl/wsr_arm_ctl.sv
module wsr_arm_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic edge_sel,
  output logic armed,
  output logic fire,
  output logic start_strobe
);

  logic armed_q;
  logic strobe_q;

  assign fire  = armed_q & edge_sel;
  assign armed = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      armed_q  <= arm | (armed_q & ~edge_sel);
      strobe_q <= fire;
    end
  end

  assign start_strobe = strobe_q;

endmodule

// File: rtl/wsr_pulse_gen.sv
module wsr_pulse_gen
  import wsr_pkg::*;
#(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);

  localparam int CW = count_width(PULSE_CYCLES);

  logic [CW-1:0] left_q;
  logic          pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else if (fire) begin
      left_q  <= CW'(PULSE_CYCLES);
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= (left_q > CW'(1));
      if (left_q != '0) left_q <= left_q - CW'(1);
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/wave_start_router.sv
module wave_start_router
  import wsr_pkg::*;
#(
  parameter int     NUM_PINS    = 10,
  parameter int     SYNC_STAGES = 2,
  parameter longint CLK_HZ      = 40_000_000,
  parameter longint PULSE_NS    = 50,
  parameter int     SEL_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS + 1) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [SEL_W-1:0]    src_sel,
  input  logic                fall_edge,
  input  logic                out_en,
  input  logic                arm,
  output logic                start_strobe,
  output logic                trig_out,
  output logic                trig_out_en
);

  localparam int PULSE_CYCLES = pulse_cycles(CLK_HZ, PULSE_NS);

  logic [NUM_PINS-1:0] pin_sync;
  logic                edge_sel;
  logic                armed;
  logic                fire;
  logic                oe_q;

  wsr_pin_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(pin_sync)
  );

  wsr_edge_pick #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .src_sel(src_sel),
    .fall_edge(fall_edge), .edge_sel(edge_sel)
  );

  wsr_arm_ctl u_arm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .edge_sel(edge_sel),
    .armed(armed), .fire(fire), .start_strobe(start_strobe)
  );

  wsr_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(trig_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else oe_q <= out_en;
  end

  assign trig_out_en = oe_q;

endmodule

// File: rtl/wsr_checker.sv
module wsr_checker #(
  parameter int NUM_PINS = 10,
  parameter int SEL_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] src_sel,
  input logic             out_en,
  input logic             start_strobe,
  input logic             trig_out,
  input logic             trig_out_en,
  input logic             armed,
  input logic             edge_sel
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!start_strobe && !trig_out && !trig_out_en));

  p_strobe_from_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |-> $past(edge_sel));

  p_strobe_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |-> $past(armed));

  p_pulse_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |-> trig_out);

  p_pulse_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> start_strobe);

  p_oe_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (trig_out_en == $past(out_en)));

  p_bad_sel_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(src_sel) >= NUM_PINS) |-> !edge_sel);

endmodule

bind wave_start_router wsr_checker #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .out_en(out_en),
  .start_strobe(start_strobe), .trig_out(trig_out), .trig_out_en(trig_out_en),
  .armed(armed), .edge_sel(edge_sel)
);

// File: tb/sim_wave_start_router.sv
`timescale 1ns/1ps
module sim_wave_start_router;

  localparam int NP    = 10;
  localparam int SW    = 4;
  localparam int LAT   = 3;                 // 2 sync stages + output register
  localparam int PW    = (50 * 40 + 999) / 1000; // 50 ns at 40 MHz in cycles

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [SW-1:0] src_sel = '0;
  logic          fall_edge = 1'b0;
  logic          out_en = 1'b0;
  logic          arm = 1'b0;
  logic          start_strobe, trig_out, trig_out_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_q[$];
  int exp_start = -100;
  string exp_tag = "R2";
  bit mon_on = 1'b0;

  always #2.5 clk = ~clk;

  wave_start_router u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .src_sel(src_sel),
    .fall_edge(fall_edge), .out_en(out_en), .arm(arm),
    .start_strobe(start_strobe), .trig_out(trig_out), .trig_out_en(trig_out_en)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: change one pin; if a start is expected, queue its strobe cycle.
  task automatic drive_pin(input int idx, input logic val, input bit expect_fire, input string tag);
    pin_in[idx] = val;
    if (expect_fire) begin
      exp_q.push_back(cyc + LAT);
      exp_start = cyc + LAT;
      exp_tag = tag;
    end
    tick(6);
  endtask

  task automatic pulse_arm();
    arm = 1'b1;
    tick(1);
    arm = 1'b0;
  endtask

  // Monitor: every strobe must match the head of the queue; pulse checked each cycle.
  always @(negedge clk) begin
    if (mon_on) begin
      if (start_strobe) begin
        if (exp_q.size() == 0) check("R4/R5/R6/R9 unexpected strobe", 1, 0);
        else check({exp_tag, " strobe cycle"}, cyc, exp_q.pop_front());
      end
      check("R7 trig_out", int'(trig_out),
            int'(cyc >= exp_start && cyc < exp_start + PW));
    end
  end

  initial begin
    #(200000 * 5);
    check("watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(1);
    check("R1 strobe in reset", int'(start_strobe), 0);
    check("R1 trig_out in reset", int'(trig_out), 0);
    check("R1 oe in reset", int'(trig_out_en), 0);
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 strobe after reset", int'(start_strobe), 0);
    check("R1 oe after reset", int'(trig_out_en), 0);
    mon_on = 1'b1;

    // R6: never armed, edge ignored
    drive_pin(0, 1'b1, 0, "R6");
    drive_pin(0, 1'b0, 0, "R6");

    // R2: arm then rising edge on pin 0
    pulse_arm();
    drive_pin(0, 1'b1, 1, "R2");
    drive_pin(0, 1'b0, 0, "R5");
    // R5: second edge without re-arm ignored
    drive_pin(0, 1'b1, 0, "R5");
    drive_pin(0, 1'b0, 0, "R5");

    // R4: other pin toggles ignored, selected pin fires
    src_sel = 4'd3;
    pulse_arm();
    drive_pin(1, 1'b1, 0, "R4");
    drive_pin(1, 1'b0, 0, "R4");
    drive_pin(3, 1'b1, 1, "R4");
    drive_pin(3, 1'b0, 0, "R4");

    // R3: falling polarity
    src_sel = 4'd5;
    fall_edge = 1'b1;
    tick(2);
    pulse_arm();
    drive_pin(5, 1'b1, 0, "R3");
    drive_pin(5, 1'b0, 1, "R3");
    fall_edge = 1'b0;
    tick(2);

    // R9: highest valid index
    src_sel = 4'(NP - 1);
    pulse_arm();
    drive_pin(NP - 1, 1'b1, 1, "R9");
    drive_pin(NP - 1, 1'b0, 0, "R9");

    // R9: out-of-range select never fires
    src_sel = 4'd12;
    pulse_arm();
    for (int p = 0; p < NP; p++) drive_pin(p, 1'b1, 0, "R9");
    for (int p = 0; p < NP; p++) drive_pin(p, 1'b0, 0, "R9");

    // R8: output enable follows one cycle later
    check("R8 oe still low", int'(trig_out_en), 0);
    out_en = 1'b1;
    tick(1);
    check("R8 oe raised", int'(trig_out_en), 1);
    out_en = 1'b0;
    tick(1);
    check("R8 oe dropped", int'(trig_out_en), 0);

    tick(4);
    check("R2 all expected strobes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule